// File: doc/BRIEF.md
# Reference-Compare Up-Counting Timer

A general purpose 16-bit timer block with a small word-wide register interface. Software programs a mode word (enable, clock source, restart, interrupt enable and an 8-bit prescale value) and a reference value. Once started, the counter steps up at a rate set by the selected clock source and the prescaler. When it equals the reference it returns to zero and records a reference event. An interrupt output follows that event while the interrupt enable is set.

Software may load the counter directly, read it back at any time, and use a plain storage word reserved for captured values. Event flags are cleared by writing ones to them. Taking the enable bit from one to zero wipes the mode word and the reference value, so a stopped timer always restarts from a known setup.

Top module: `gpt_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Registers sit at byte offsets 0x00 mode, 0x04 reference, 0x08 capture, 0x0C counter and 0x11 event. Any other offset reads as zero, and a write to it changes no register.
- R3: A mode write with bit 0 clear, while the stored bit 0 is set, leaves the mode and reference registers at zero. Any other mode write stores the written value.
- R4: Mode bits 2:1 select the counting clock. Value 1 gives one tick per clock and value 2 gives one tick per 16 clocks. Values 0 and 3 keep the counter stopped.
- R5: With prescale value P in mode bits 15:8, the counter steps once per P+1 selected ticks.
- R6: The counter runs only while mode bit 0 and mode bit 3 are both set. A step taken while the counter equals the reference returns it to zero and sets event bit 1 on that same edge.
- R7: `irq_o` is high exactly when mode bit 4 and event bit 1 are both set.
- R8: Writing the event register clears each flag whose bit is one in the written value. Flags whose bit is zero are kept.
- R9: A counter write loads the written value on that edge and overrides a step due on the same edge.
- R10: A write to the mode or reference register restarts the prescaler and the divide-by-16 stage from zero.
- R11: The capture register stores and returns any written 16-bit value and does not affect counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Reference interrupt |

## Verification
The counting path is driven with every clock-source code, prescale values of zero and above, and reference values below and above the number of steps. These cases separate a wrong tick rate from a wrong wrap point, and a wrap from a missing event. A reference of zero checks the wrap on the very first step. With the restart or enable bit cleared, the bench tells a gated counter from one that runs. Directed cases set the mode clear on disable against a plain mode store, a one-bit event clear against a full clear, and a counter load against a competing step. A reference rewrite made in the middle of a prescale period shows whether the prescaler restarts.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   // byte offsets decoded by the register file
   localparam int OFF_MODE = 'h00;
   localparam int OFF_REF  = 'h04;
   localparam int OFF_CAP  = 'h08;
   localparam int OFF_CNT  = 'h0C;
   localparam int OFF_EVT  = 'h11;

   // mode word bit positions
   localparam int MB_EN      = 0;
   localparam int MB_SRC_LO  = 1;
   localparam int MB_RESTART = 3;
   localparam int MB_IRQEN   = 4;
   localparam int MB_PRESC   = 8;

   // event word bit positions
   localparam int EB_CAP = 0;
   localparam int EB_REF = 1;

   typedef enum logic [1:0] {
      SRC_OFF_A = 2'd0,
      SRC_SYS   = 2'd1,
      SRC_SYS16 = 2'd2,
      SRC_OFF_B = 2'd3
   } clk_src_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int PRE_W    = 8,
   parameter int DIV_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             use_div,
   input  logic [PRE_W-1:0] presc,
   input  logic             clr,
   output logic             step
);
   logic             base_tick;
   logic [PRE_W-1:0] pcnt_q;

   generate
      if (DIV_LOG2 == 0) begin : g_nodiv
         assign base_tick = run;
      end else begin : g_div
         logic [DIV_LOG2-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (clr)            div_q <= '0;
            else if (run && use_div) div_q <= div_q + 1'b1;
         end
         assign base_tick = run && (!use_div || (&div_q));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pcnt_q <= '0;
      else if (clr)            pcnt_q <= '0;
      else if (base_tick) begin
         if (pcnt_q == presc)  pcnt_q <= '0;
         else                  pcnt_q <= pcnt_q + 1'b1;
      end
   end

   assign step = base_tick && (pcnt_q == presc) && !clr;

   // consecutive steps are impossible once the prescale value is nonzero
   a_r5_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (step && presc != '0 && $stable(presc)) |=> !step);
   // a prescaler restart cancels any step on that edge
   a_r10_clr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !step);
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] ref_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ref_hit
);
   assign ref_hit = step && !load && (cnt_q == ref_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (load)     cnt_q <= load_val;
      else if (step) begin
         if (cnt_q == ref_val) cnt_q <= '0;
         else                  cnt_q <= cnt_q + 1'b1;
      end
   end

   a_r6_wrap_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cnt_q == ref_val) |=> (cnt_q == '0));
   a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));
   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/gpt_regfile.sv
module gpt_regfile
   import gpt_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              ref_hit,
   output logic [MB_PRESC+PRE_W-1:0] mode_q,
   output logic [CNT_W-1:0]  ref_q,
   output logic              presc_clr,
   output logic              cnt_load,
   output logic              irq_o
);
   localparam int MODE_W = MB_PRESC + PRE_W;

   logic [DATA_W-1:0] cap_q;
   logic [1:0]        evt_q;
   logic              wr_mode, wr_ref, wr_cap, wr_evt, wr_go;
   logic              disable_wr;
   logic [1:0]        evt_clr, evt_set;

   assign wr_go   = bus_sel && bus_wr;
   assign wr_mode = wr_go && (int'(bus_addr) == OFF_MODE);
   assign wr_ref  = wr_go && (int'(bus_addr) == OFF_REF);
   assign wr_cap  = wr_go && (int'(bus_addr) == OFF_CAP);
   assign cnt_load = wr_go && (int'(bus_addr) == OFF_CNT);
   assign wr_evt  = wr_go && (int'(bus_addr) == OFF_EVT);

   assign disable_wr = wr_mode && mode_q[MB_EN] && !bus_wdata[MB_EN];
   assign presc_clr  = wr_mode || wr_ref;

   assign evt_clr = wr_evt ? bus_wdata[1:0] : 2'b00;
   assign evt_set = {ref_hit, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '0;
         cap_q  <= '0;
         evt_q  <= '0;
      end else begin
         if (disable_wr) begin
            mode_q <= '0;
            ref_q  <= '0;
         end else begin
            if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
            if (wr_ref)  ref_q  <= bus_wdata[CNT_W-1:0];
         end
         if (wr_cap) cap_q <= bus_wdata;
         evt_q <= (evt_q & ~evt_clr) | evt_set;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (int'(bus_addr))
         OFF_MODE: bus_rdata[MODE_W-1:0] = mode_q;
         OFF_REF:  bus_rdata[CNT_W-1:0]  = ref_q;
         OFF_CAP:  bus_rdata             = cap_q;
         OFF_CNT:  bus_rdata[CNT_W-1:0]  = cnt_q;
         OFF_EVT:  bus_rdata[1:0]        = evt_q;
         default:  bus_rdata             = '0;
      endcase
   end

   assign irq_o = mode_q[MB_IRQEN] && evt_q[EB_REF];

   a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      disable_wr |=> (mode_q == '0 && ref_q == '0));
   a_r8_w1c_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && bus_wdata[EB_REF] && !ref_hit) |=> !evt_q[EB_REF]);
   a_r6_hit_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ref_hit |=> evt_q[EB_REF]);
   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(ref_hit) || $past(wr_mode)));
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
   import gpt_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 16,
   parameter int PRE_W    = 8,
   parameter int DIV_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int MODE_W = MB_PRESC + PRE_W;

   generate
      if (ADDR_W < 5)       begin : g_chk_addr $error("ADDR_W must reach offset 0x11"); end
      if (DATA_W < MODE_W)  begin : g_chk_mode $error("DATA_W too narrow for mode word"); end
      if (DATA_W < CNT_W)   begin : g_chk_cnt  $error("DATA_W too narrow for counter"); end
      if (PRE_W < 1)        begin : g_chk_pre  $error("PRE_W must be positive"); end
      if (DIV_LOG2 < 0)     begin : g_chk_div  $error("DIV_LOG2 must not be negative"); end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  ref_q, cnt_q;
   logic              presc_clr, cnt_load, step, ref_hit, run;
   clk_src_e          src;

   assign src = clk_src_e'(mode_q[MB_SRC_LO +: 2]);
   assign run = mode_q[MB_EN] && mode_q[MB_RESTART] &&
                (src == SRC_SYS || src == SRC_SYS16);

   gpt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_q(cnt_q), .ref_hit(ref_hit),
      .mode_q(mode_q), .ref_q(ref_q),
      .presc_clr(presc_clr), .cnt_load(cnt_load), .irq_o(irq_o)
   );

   gpt_prescaler #(.PRE_W(PRE_W), .DIV_LOG2(DIV_LOG2)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run),
      .use_div(src == SRC_SYS16),
      .presc(mode_q[MB_PRESC +: PRE_W]),
      .clr(presc_clr), .step(step)
   );

   gpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_load),
      .load_val(bus_wdata[CNT_W-1:0]), .ref_val(ref_q),
      .cnt_q(cnt_q), .ref_hit(ref_hit)
   );

   a_r1_irq_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[MB_IRQEN] |-> !irq_o);
   a_r6_no_step_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !step);
endmodule

// File: tb/tb_gpt_timer.sv
module tb_gpt_timer;
   localparam int CLK_P = 10;

   logic        clk = 0, rst_n = 0;
   logic        bus_sel = 0, bus_wr = 0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic        irq_o;
   int n_chk = 0, n_fail = 0;

   gpt_timer dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                  .bus_rdata(bus_rdata), .irq_o(irq_o));

   always #(CLK_P/2) clk = ~clk;

   localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                          A_CNT = 5'h0C, A_EVT = 5'h11;

   typedef struct packed {
      logic [15:0] mode;
      logic [15:0] refv;
      logic [15:0] n;
      logic [15:0] cnt;
      logic [1:0]  ev;
      logic        irq;
   } vec_t;

   // expected count = steps mod (ref+1); event once steps > ref
   localparam vec_t VEC [12] = '{
      '{16'h0009, 16'd5,   16'd10, 16'd0,  2'b00, 1'b0},  // R4 src 0 stopped
      '{16'h000B, 16'd100, 16'd10, 16'd10, 2'b00, 1'b0},  // R4 src 1
      '{16'h000B, 16'd3,   16'd10, 16'd2,  2'b10, 1'b0},  // R6 wrap
      '{16'h020B, 16'd100, 16'd10, 16'd3,  2'b00, 1'b0},  // R5 P=2
      '{16'h000D, 16'd100, 16'd50, 16'd3,  2'b00, 1'b0},  // R4 div16
      '{16'h010D, 16'd1,   16'd70, 16'd0,  2'b10, 1'b0},  // R5 div16 P=1
      '{16'h000F, 16'd5,   16'd10, 16'd0,  2'b00, 1'b0},  // R4 src 3 stopped
      '{16'h0003, 16'd5,   16'd10, 16'd0,  2'b00, 1'b0},  // R6 no restart
      '{16'h000A, 16'd5,   16'd10, 16'd0,  2'b00, 1'b0},  // R6 not enabled
      '{16'h000B, 16'd0,   16'd4,  16'd0,  2'b10, 1'b0},  // R6 ref zero
      '{16'h001B, 16'd2,   16'd5,  16'd2,  2'b10, 1'b1},  // R7 irq on
      '{16'h001B, 16'd9,   16'd5,  16'd5,  2'b00, 1'b0}   // R7 irq off
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic setup(input logic [15:0] refv, input logic [15:0] mode);
      wr(A_MODE, 16'h0000);
      wr(A_CNT, 16'h0000);
      wr(A_EVT, 16'h0003);
      wr(A_REF, refv);
      wr(A_MODE, mode);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] v;
      #(CLK_P * 3 + 2);
      // R1 reset state
      rd(A_MODE, v); check("R1 mode", v, 16'h0);
      rd(A_REF, v);  check("R1 ref", v, 16'h0);
      rd(A_CNT, v);  check("R1 cnt", v, 16'h0);
      rd(A_EVT, v);  check("R1 evt", v, 16'h0);
      check("R1 irq", {15'b0, irq_o}, 16'h0);
      rst_n = 1;
      idle(1);

      foreach (VEC[i]) begin
         setup(VEC[i].refv, VEC[i].mode);
         idle(int'(VEC[i].n));
         rd(A_CNT, v); check($sformatf("R4/R5/R6 vec%0d cnt", i), v, VEC[i].cnt);
         rd(A_EVT, v); check($sformatf("R6 vec%0d evt", i), v, {14'b0, VEC[i].ev});
         check($sformatf("R7 vec%0d irq", i), {15'b0, irq_o}, {15'b0, VEC[i].irq});
      end

      // R8: clearing bit 0 keeps ref flag, clearing bit 1 drops it and irq
      setup(16'd0, 16'h001B);
      idle(2);
      wr(A_MODE, 16'h0018);     // enable off clears mode and ref
      wr(A_EVT, 16'h0001);
      rd(A_EVT, v); check("R8 keep ref flag", v, 16'h2);
      wr(A_MODE, 16'h0010);     // irq enable, stopped
      check("R7 irq with stopped timer", {15'b0, irq_o}, 16'h1);
      wr(A_EVT, 16'h0002);
      rd(A_EVT, v); check("R8 ref flag cleared", v, 16'h0);
      check("R7 irq dropped", {15'b0, irq_o}, 16'h0);

      // R3: disable write clears mode and ref; plain store otherwise
      wr(A_MODE, 16'h0000);
      wr(A_MODE, 16'h0350);
      rd(A_MODE, v); check("R3 plain store", v, 16'h0350);
      wr(A_REF, 16'd77);
      wr(A_MODE, 16'h001B);
      wr(A_MODE, 16'h00F0);
      rd(A_MODE, v); check("R3 mode cleared", v, 16'h0);
      rd(A_REF, v);  check("R3 ref cleared", v, 16'h0);

      // R9: load overrides the step on the same edge
      setup(16'd100, 16'h000B);
      wr(A_CNT, 16'd50);
      idle(3);
      rd(A_CNT, v); check("R9 load then count", v, 16'd53);
      wr(A_MODE, 16'h0000);
      wr(A_CNT, 16'h1234);
      rd(A_CNT, v); check("R9 load stopped", v, 16'h1234);

      // R10: reference rewrite restarts the prescaler
      setup(16'd100, 16'h030B);
      idle(2);
      wr(A_REF, 16'd100);
      idle(3);
      rd(A_CNT, v); check("R10 no step yet", v, 16'd0);
      idle(1);
      rd(A_CNT, v); check("R10 first step", v, 16'd1);

      // R11: capture storage
      wr(A_MODE, 16'h0000);
      wr(A_CAP, 16'hBEEF);
      rd(A_CAP, v); check("R11 capture", v, 16'hBEEF);
      rd(A_CNT, v); check("R11 counter untouched", v, 16'd1);

      // R2: unmapped offsets
      wr(5'h14, 16'hFFFF);
      rd(5'h14, v);  check("R2 unmapped read", v, 16'h0);
      rd(5'h10, v);  check("R2 gap read", v, 16'h0);
      rd(A_MODE, v); check("R2 mode kept", v, 16'h0);
      rd(A_CAP, v);  check("R2 cap kept", v, 16'hBEEF);
      rd(A_CNT, v);  check("R2 cnt kept", v, 16'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule